// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets synchronous logic use an external asynchronous static RAM of one million 4-bit words that shares one bidirectional data bus for reads and writes. The user side is a request/acknowledge handshake. The user holds `req` high with an address, a write flag and write data until `ack` pulses, and read data is returned on `rdata` in that same cycle. The memory side drives the address, the active-low chip select, write enable and output enable strobes, outgoing data with a separate drive enable, and an incoming data bus. The tristate pad sits outside the block.

The nanosecond limits of the memory are parameters. Each limit is converted into a clock-cycle count by rounding up, and any nonzero limit costs at least one cycle. Every strobe comes straight from a register.

A write-style parameter selects how writes are done. In the first style, output enable stays high. The controller waits out the output-disable window and then pulls write enable low while it drives data. In the second style, output enable stays low. Write enable falls at the start, the bus is left undriven while the memory's outputs turn off, and then data is driven for long enough to satisfy the longer pulse that this style requires.

Top module: `sram_timing_ctrl`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dout_en` and `ack` are 0, and the controller accepts a request on the first edge at which `req` is 1.
- R2: Strobe encoding. With `mem_cs_n`=1, `mem_we_n` is 1 and `mem_dout_en` is 0. A read is `mem_cs_n`=0, `mem_we_n`=1, `mem_oe_n`=0. `mem_we_n` is 0 only while `mem_cs_n` is 0.
- R3: A read raises `ack` and loads `rdata` from `mem_din` on the edge that lies RD cycles after the accepting edge. RD is the largest of the address-access, output-enable-access and read-cycle limits, each divided by the clock period and rounded up (10 ns, 5 ns and 10 ns at a 3 ns period give 4).
- R4: `ack` is high for exactly one cycle. Changes on `req_addr`, `req_we` and `req_wdata` between the accepting edge and `ack` have no effect on the access in progress.
- R5: `mem_addr` stays constant for as long as `mem_cs_n` stays 0.
- R6: Output-enable-high style. `mem_oe_n` stays 1 for the whole write. For TURN = ceil(output-disable limit) cycles (2 at 5 ns / 3 ns), the bus shows `mem_cs_n`=0 and `mem_we_n`=1 with no drive. After that, `mem_we_n`=0 and the data is driven for max(ceil(write pulse), ceil(data setup)) cycles (3). The acknowledge comes 5 cycles after accept.
- R7: Output-enable-low style. `mem_oe_n` stays 0 and `mem_we_n` falls when the write is accepted. The first TURN cycles (2) are undriven. Data is then driven for max(ceil(data setup), ceil(long pulse) − TURN) cycles (2), so write enable is low for 4 cycles. The acknowledge comes 4 cycles after accept.
- R8: A write ends on a single edge on which `mem_we_n` and `mem_cs_n` rise, the drive turns off and `ack` rises. `mem_dout` and `mem_addr` stay constant while data is driven, and the memory ends up holding that value.
- R9: `mem_dout_en` is never 1 while the memory could be driving, which is when `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1. The drive is on only inside the write window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Read data, valid with `ack` of a read |
| mem_addr | output | 20 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dout | output | 4 | Data toward the memory |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 4 | Data from the memory |

## Verification
The bench runs one instance of each write style at a 3 ns period setting. At that setting a read acknowledges 4 cycles after the accepting edge, an output-enable-high write acknowledges after 5 cycles, and an output-enable-low write acknowledges after 4. Inputs change at falling edges and outputs are sampled at falling edges. The bench counts the falling edges after the request is raised, so the k-th sample shows the result of accepting edge plus k−1, and each latency is compared with these numbers. A falling-edge monitor measures how many cycles each phase of a write lasts. It then commits the driven value into a behavioural memory, and the phase lengths are checked against R6 and R7 once the write completes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WTURN,
        ST_WDATA,
        ST_DONE
    } ctrl_state_e;

    // Round a limit up to whole clock cycles; a nonzero limit costs at least one.
    function automatic int cyc_of(input int limit_ps, input int clk_ps);
        if (limit_ps <= 0) return 0;
        return (limit_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (capture) hold_d = bus_in;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    assign rdata = hold_q;

endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 4,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int T_ACC_ADDR_PS = 10000,
    parameter int T_ACC_OE_PS   = 5000,
    parameter int T_CYCLE_PS    = 10000,
    parameter int T_PULSE_PS    = 7000,
    parameter int T_PULSE_OL_PS = 10000,
    parameter int T_DSETUP_PS   = 5000,
    parameter int T_RELEASE_PS  = 5000,
    parameter bit WRITE_OE_LOW  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int RD_CYC   = imax(imax(imax(cyc_of(T_ACC_ADDR_PS, CLK_PERIOD_PS),
                                             cyc_of(T_ACC_OE_PS, CLK_PERIOD_PS)),
                                        cyc_of(T_CYCLE_PS, CLK_PERIOD_PS)), 1);
    localparam int TURN_CYC = imax(cyc_of(T_RELEASE_PS, CLK_PERIOD_PS), 1);
    localparam int DATA_HI  = imax(cyc_of(T_PULSE_PS, CLK_PERIOD_PS),
                                   cyc_of(T_DSETUP_PS, CLK_PERIOD_PS));
    localparam int DATA_LO  = imax(cyc_of(T_DSETUP_PS, CLK_PERIOD_PS),
                                   cyc_of(T_PULSE_OL_PS, CLK_PERIOD_PS) - TURN_CYC);
    localparam int DATA_CYC = imax(WRITE_OE_LOW ? DATA_LO : DATA_HI, 1);
    localparam int MAX_CYC  = imax(RD_CYC, imax(TURN_CYC, DATA_CYC));
    localparam int CNT_W    = imax($clog2(MAX_CYC + 1), 1);
    // Strobe levels held during the turnaround phase of a write.
    localparam logic TURN_WE_N = WRITE_OE_LOW ? 1'b0 : 1'b1;
    localparam logic TURN_OE_N = WRITE_OE_LOW ? 1'b0 : 1'b1;

    typedef struct packed {
        ctrl_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic              ack;
    } ctrl_regs_t;

    localparam ctrl_regs_t RST_VAL = '{
        st: ST_IDLE, addr: '0, wdata: '0,
        cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0, ack: 1'b0
    };

    ctrl_regs_t       r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             cap_en;

    always_comb begin
        r_d      = r_q;
        r_d.ack  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.cs_n  = 1'b0;
                    tmr_load  = 1'b1;
                    if (req_we) begin
                        r_d.st   = ST_WTURN;
                        r_d.we_n = TURN_WE_N;
                        r_d.oe_n = TURN_OE_N;
                        tmr_val  = CNT_W'(TURN_CYC - 1);
                    end else begin
                        r_d.st   = ST_RD;
                        r_d.oe_n = 1'b0;
                        tmr_val  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD: begin
                if (tmr_done) begin
                    cap_en   = 1'b1;
                    r_d.ack  = 1'b1;
                    r_d.cs_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.st   = ST_DONE;
                end
            end
            ST_WTURN: begin
                if (tmr_done) begin
                    r_d.we_n = 1'b0;
                    r_d.drv  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(DATA_CYC - 1);
                    r_d.st   = ST_WDATA;
                end
            end
            ST_WDATA: begin
                if (tmr_done) begin
                    r_d.we_n = 1'b1;
                    r_d.cs_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.drv  = 1'b0;
                    r_d.ack  = 1'b1;
                    r_d.st   = ST_DONE;
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= RST_VAL;
        else     r_q <= r_d;
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .capture (cap_en),
        .bus_in  (mem_din),
        .rdata   (rdata)
    );

    assign ack         = r_q.ack;
    assign mem_addr    = r_q.addr;
    assign mem_cs_n    = r_q.cs_n;
    assign mem_we_n    = r_q.we_n;
    assign mem_oe_n    = r_q.oe_n;
    assign mem_dout    = r_q.wdata;
    assign mem_dout_en = r_q.drv;

    // R2
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    // R9
    drive_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> (!mem_we_n && !mem_cs_n));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R4
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R8
    write_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_cs_n && !mem_dout_en && ack));

    // R8
    wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout));

    if (WRITE_OE_LOW) begin : g_oe_low
        // R7
        turn_undriven_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(mem_we_n) |-> !mem_dout_en);
        // R7
        oe_low_write_chk: assert property (@(posedge clk) disable iff (rst)
            !mem_we_n |-> !mem_oe_n);
    end else begin : g_oe_high
        // R6
        oe_high_write_chk: assert property (@(posedge clk) disable iff (rst)
            !mem_we_n |-> mem_oe_n);
        // R6
        release_first_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(mem_cs_n) |-> mem_we_n);
    end

endmodule

// File: tb/sram_timing_ctrl_bench.sv
module sram_timing_ctrl_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic [1:0]  req = 2'b00;
    logic        we_in = 1'b0;
    logic [19:0] addr_in = '0;
    logic [3:0]  wd_in = '0;

    logic [1:0]  ack, cs_n, we_n, oe_n, den;
    logic [3:0]  rdat0, rdat1, dout0, dout1, din0, din1;
    logic [19:0] maddr0, maddr1;

    sram_timing_ctrl #(.CLK_PERIOD_PS(3000), .WRITE_OE_LOW(1'b0)) u_sram_timing_ctrl (
        .clk(clk), .rst(rst), .req(req[0]), .req_we(we_in), .req_addr(addr_in),
        .req_wdata(wd_in), .ack(ack[0]), .rdata(rdat0), .mem_addr(maddr0),
        .mem_cs_n(cs_n[0]), .mem_we_n(we_n[0]), .mem_oe_n(oe_n[0]),
        .mem_dout(dout0), .mem_dout_en(den[0]), .mem_din(din0));

    sram_timing_ctrl #(.CLK_PERIOD_PS(3000), .WRITE_OE_LOW(1'b1)) u_sram_timing_ctrl_oelow (
        .clk(clk), .rst(rst), .req(req[1]), .req_we(we_in), .req_addr(addr_in),
        .req_wdata(wd_in), .ack(ack[1]), .rdata(rdat1), .mem_addr(maddr1),
        .mem_cs_n(cs_n[1]), .mem_we_n(we_n[1]), .mem_oe_n(oe_n[1]),
        .mem_dout(dout1), .mem_dout_en(den[1]), .mem_din(din1));

    // Behavioural memory, one address space per instance.
    logic [3:0] mem [int];
    function automatic logic [3:0] peek(input int key);
        if (mem.exists(key)) return mem[key];
        return 4'h0;
    endfunction
    always @* din0 = (!cs_n[0] && !oe_n[0] && we_n[0]) ? peek(int'(maddr0)) : 4'h0;
    always @* din1 = (!cs_n[1] && !oe_n[1] && we_n[1]) ? peek(32'h100000 + int'(maddr1)) : 4'h0;

    int n_chk = 0, n_err = 0;
    int mode_err = 0, cont_err = 0, stab_err = 0;
    logic [1:0] busy = 2'b00;
    int turn_c[2], wlow_c[2], drv_c[2], pre_c[2];
    int r_turn[2], r_wlow[2], r_drv[2], r_pre[2];
    logic [3:0]  wdat[2];
    logic [19:0] wadr[2];

    // Falling-edge monitor: phase lengths, encoding and contention, memory commit.
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 2; i++) begin
                logic [3:0]  dv;
                logic [19:0] av;
                dv = (i == 0) ? dout0 : dout1;
                av = (i == 0) ? maddr0 : maddr1;
                if (cs_n[i]) begin
                    if (!we_n[i] || den[i]) mode_err++;
                    if (busy[i]) begin
                        busy[i]   = 1'b0;
                        r_turn[i] = turn_c[i];
                        r_wlow[i] = wlow_c[i];
                        r_drv[i]  = drv_c[i];
                        r_pre[i]  = pre_c[i];
                        if (drv_c[i] > 0) mem[i * 32'h100000 + int'(wadr[i])] = wdat[i];
                    end
                end else begin
                    if (!busy[i]) begin
                        busy[i] = 1'b1;
                        turn_c[i] = 0; wlow_c[i] = 0; drv_c[i] = 0; pre_c[i] = 0;
                    end
                    if (we_n[i] && oe_n[i]) turn_c[i]++;
                    if (!we_n[i]) begin
                        wlow_c[i]++;
                        if (!den[i]) pre_c[i]++;
                    end
                    if (den[i]) begin
                        if (drv_c[i] == 0) begin
                            wdat[i] = dv; wadr[i] = av;
                        end else if (dv != wdat[i] || av != wadr[i]) stab_err++;
                        drv_c[i]++;
                        if (!oe_n[i] && we_n[i]) cont_err++;
                    end
                end
            end
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    bit finished = 1'b0;
    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // Runs one request on both instances; latencies count edges after the accepting edge.
    task automatic run_op(input logic w, input logic [19:0] a, input logic [3:0] d,
                          input bit poke, output int lat0, output int lat1);
        logic [1:0] done;
        int k;
        @(negedge clk);
        we_in = w; addr_in = a; wd_in = d; req = 2'b11;
        done = 2'b00; k = 0; lat0 = -1; lat1 = -1;
        while (done != 2'b11 && k < 40) begin
            @(negedge clk);
            k++;
            if (poke && k == 2) begin
                addr_in = ~a; wd_in = ~d; we_in = ~w;
            end
            if (!done[0] && ack[0]) begin done[0] = 1'b1; req[0] = 1'b0; lat0 = k - 1; end
            if (!done[1] && ack[1]) begin done[1] = 1'b1; req[1] = 1'b0; lat1 = k - 1; end
        end
        req = 2'b00;
        @(negedge clk);
        chk("R4", "ack single cycle", int'(ack), 0);
    endtask

    task automatic t_reset();
        chk("R1", "cs_n", int'(cs_n), 3);
        chk("R1", "we_n", int'(we_n), 3);
        chk("R1", "oe_n", int'(oe_n), 3);
        chk("R1", "drive enable", int'(den), 0);
        chk("R1", "ack", int'(ack), 0);
    endtask

    task automatic t_write(input logic [19:0] a, input logic [3:0] d, input bit poke);
        int l0, l1;
        run_op(1'b1, a, d, poke, l0, l1);
        chk("R6", "oe-high write latency", l0, 5);
        chk("R6", "oe-high turnaround cycles", r_turn[0], 2);
        chk("R6", "oe-high we low cycles", r_wlow[0], 3);
        chk("R6", "oe-high drive cycles", r_drv[0], 3);
        chk("R7", "oe-low write latency", l1, 4);
        chk("R7", "oe-low we low cycles", r_wlow[1], 4);
        chk("R7", "oe-low undriven we low cycles", r_pre[1], 2);
        chk("R7", "oe-low drive cycles", r_drv[1], 2);
        chk("R7", "oe-low output disable cycles", r_turn[1], 0);
    endtask

    task automatic t_read(input logic [19:0] a, input logic [3:0] exp, input bit poke);
        int l0, l1;
        run_op(1'b0, a, 4'h0, poke, l0, l1);
        chk("R3", "read latency oe-high inst", l0, 4);
        chk("R3", "read latency oe-low inst", l1, 4);
        chk(poke ? "R4" : "R3", "rdata oe-high inst", int'(rdat0), int'(exp));
        chk(poke ? "R4" : "R3", "rdata oe-low inst", int'(rdat1), int'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write(20'h00000, 4'h5, 1'b0);
        t_write(20'hFFFFF, 4'hA, 1'b0);
        t_write(20'h12345, 4'h3, 1'b0);
        t_read(20'h00000, 4'h5, 1'b0);
        t_read(20'hFFFFF, 4'hA, 1'b0);
        t_read(20'h12345, 4'h3, 1'b0);
        t_write(20'h12345, 4'hC, 1'b0);
        t_read(20'h12345, 4'hC, 1'b0);
        // R4: inputs scrambled mid-access must not redirect a read.
        t_read(20'h00000, 4'h5, 1'b1);
        t_read(20'hFFFFF, 4'hA, 1'b0);
        // R4 / R8: a scrambled write still lands on its own address only.
        t_write(20'h0ABCD, 4'h6, 1'b1);
        t_read(20'h0ABCD, 4'h6, 1'b0);
        t_read(20'hF5432, 4'h0, 1'b0);
        chk("R2", "strobe encoding violations", mode_err, 0);
        chk("R9", "bus contention cycles", cont_err, 0);
        chk("R8", "data or address moved while driven", stab_err, 0);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule